// File: doc/BRIEF.md
# Multi-Rate ADC Lane Packer

This block collects 12-bit samples from 32 ADC channels and distributes them over a set of parallel output lanes. Every lane carries one sample word per clock cycle in every mode. A mode setting chooses how many channels share a lane. At the full rate, two channels share each of 16 lanes. At half rate, four channels share each of 8 lanes. At quarter rate, eight channels share each of 4 lanes. The channels sample proportionally slower in the slower modes, so the lane rate does not change.

Each channel pushes its samples into an 8-entry FIFO through a valid-qualified input. This input has no back-pressure: a sample offered to a full FIFO is lost, and a sticky per-channel flag records the loss. Each active lane visits its group of channels in a fixed ascending order, one channel per cycle. If the FIFO it visits is empty, the lane emits a zero word with valid low and sets a sticky underflow flag for that channel. The output has no ready. The receiver must accept every word, and `lane_valid` tells it which words carry data. A new mode is loaded only on a resync pulse. The same pulse flushes all FIFOs and restarts the rotation. The channel FIFOs are written in the block clock domain, and the per-channel `s_valid` strobes stand for each channel's sampling clock.

Top module: `lane_mapper`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, all lane words are zero, `lane_valid` is zero, both flag vectors are zero and the full-rate mode is in force (`lane_en` all ones).
- R2: The mode codes on `mode_sel` are 0 = full (2 channels per lane), 1 = half (4 per lane), 2 = quarter (8 per lane) and 3 = the same as quarter. `mode_sel` is loaded only in a cycle with `resync` high. At any other time a change on it has no effect on `lane_en` or on lane order.
- R3: With N channels per lane, lane k serves channels k*N to k*N+N-1. In the j-th cycle after a resync or reset (j counting from 0), lane k reads channel k*N + (j mod N), so the channels of a group are visited in ascending order.
- R4: A word read in one cycle appears on the lane's slice of `lane_data` (bits k*12 upward) with `lane_valid[k]` high after the next rising edge. Each channel's samples leave in the order they were accepted.
- R5: When an active lane visits an empty FIFO, the lane's word is zero with `lane_valid[k]` low, and `unf_flags[c]` is set and stays set until reset. A sample written in that same cycle is not yet visible.
- R6: `lane_en[k]` is high exactly when k < 32/N. Lanes with the bit low read nothing and hold zero data with valid low.
- R7: Each FIFO holds 8 samples. A sample offered while 8 are held is dropped, even if one is read in that cycle, and `ovf_flags[c]` is set and stays set until reset.
- R8: A cycle with `resync` high empties every FIFO, discards any sample offered in that cycle without flagging it, restarts the rotation at slot 0, and makes all lanes invalid in the next cycle. It does not clear the flags.
- R9: The input side has no ready. Any cycle with `s_valid[c]` high offers one sample from bits c*12 upward of `s_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one lane word per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Requested rate mode, taken at resync |
| resync | input | 1 | Synchronous flush and mode load |
| s_valid | input | 32 | Per-channel sample strobe |
| s_data | input | 384 | 32 packed 12-bit samples |
| lane_data | output | 192 | 16 packed 12-bit lane words |
| lane_valid | output | 16 | Word on the lane carries a sample |
| lane_en | output | 16 | Lane is active in the current mode |
| ovf_flags | output | 32 | Sticky per-channel drop flag |
| unf_flags | output | 32 | Sticky per-channel empty-turn flag |

## Verification
The bench builds the block with its defaults: 32 channels, 12-bit samples and 8-deep FIFOs, giving 16 lanes. With these values every mode maps all 32 channels, and the three group sizes exercise the rotation wrap at 2, 4 and 8 slots. The shallow FIFOs let full-rate writes on every cycle reach overflow within a few tens of cycles, and idle stretches reach underflow at once. Mode 3, a mode change without resync, and a resync with samples in flight are all reached within a run of about a thousand cycles.

// File: rtl/lane_mapper_pkg.sv
package lane_mapper_pkg;
  typedef enum logic [1:0] {
    RATE_FULL    = 2'd0,
    RATE_HALF    = 2'd1,
    RATE_QUARTER = 2'd2,
    RATE_ALT_Q   = 2'd3
  } rate_mode_e;

  localparam int unsigned MAX_GROUP_LOG = 3;

  function automatic logic [1:0] group_log(input logic [1:0] mode);
    case (mode)
      2'd0:    group_log = 2'd1;
      2'd1:    group_log = 2'd2;
      default: group_log = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/chan_fifo.sv
module chan_fifo #(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             drop
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             full, do_wr, do_rd;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_wr   = wr_en && !full && !clr;
  assign do_rd   = rd_en && !empty && !clr;
  assign drop    = wr_en && full && !clr;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      count <= count + CW'(do_wr) - CW'(do_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end
endmodule

// File: rtl/lane_mux.sv
module lane_mux #(
  parameter int unsigned LANE     = 0,
  parameter int unsigned NUM_CH   = 32,
  parameter int unsigned WIDTH    = 12,
  parameter int unsigned SLOT_W   = 3,
  localparam int unsigned CH_W    = $clog2(NUM_CH)
) (
  input  logic [1:0]                   glog,
  input  logic [SLOT_W-1:0]            slot,
  input  logic [NUM_CH-1:0][WIDTH-1:0] heads,
  input  logic [NUM_CH-1:0]            empties,
  output logic                         active,
  output logic [CH_W-1:0]              sel,
  output logic                         take,
  output logic                         miss,
  output logic [WIDTH-1:0]             word
);
  int unsigned base;
  int unsigned offs;

  always_comb begin
    base   = LANE << glog;
    offs   = 32'(slot) & ((32'd1 << glog) - 32'd1);
    active = (LANE < (NUM_CH >> glog));
    sel    = active ? CH_W'(base + offs) : '0;
    take   = active && !empties[sel];
    miss   = active && empties[sel];
    word   = take ? heads[sel] : '0;
  end
endmodule

// File: rtl/lane_mapper.sv
module lane_mapper
  import lane_mapper_pkg::*;
#(
  parameter int unsigned NUM_CH     = 32,
  parameter int unsigned SAMPLE_W   = 12,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned NUM_LANES  = NUM_CH / 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [1:0]                      mode_sel,
  input  logic                            resync,
  input  logic [NUM_CH-1:0]               s_valid,
  input  logic [NUM_CH*SAMPLE_W-1:0]      s_data,
  output logic [NUM_LANES*SAMPLE_W-1:0]   lane_data,
  output logic [NUM_LANES-1:0]            lane_valid,
  output logic [NUM_LANES-1:0]            lane_en,
  output logic [NUM_CH-1:0]               ovf_flags,
  output logic [NUM_CH-1:0]               unf_flags
);
  localparam int unsigned CH_W   = $clog2(NUM_CH);
  localparam int unsigned SLOT_W = MAX_GROUP_LOG;

  logic [1:0]                       mode_q;
  logic [1:0]                       glog;
  logic [SLOT_W-1:0]                slot_q;
  logic [NUM_CH-1:0][SAMPLE_W-1:0]  in_words;
  logic [NUM_CH-1:0][SAMPLE_W-1:0]  heads;
  logic [NUM_CH-1:0]                empties, drops, pops, misses;
  logic [NUM_LANES-1:0]             act, takes, lmiss;
  logic [NUM_LANES-1:0][CH_W-1:0]   sels;
  logic [NUM_LANES-1:0][SAMPLE_W-1:0] words, lane_q;
  logic [NUM_LANES-1:0]             valid_q;

  assign in_words   = s_data;
  assign glog       = group_log(mode_q);
  assign lane_data  = lane_q;
  assign lane_valid = valid_q;
  assign lane_en    = act;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_fifo #(.WIDTH(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (resync),
      .wr_en   (s_valid[c]),
      .wr_data (in_words[c]),
      .rd_en   (pops[c]),
      .rd_data (heads[c]),
      .empty   (empties[c]),
      .drop    (drops[c])
    );
  end

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    lane_mux #(.LANE(k), .NUM_CH(NUM_CH), .WIDTH(SAMPLE_W), .SLOT_W(SLOT_W)) u_mux (
      .glog    (glog),
      .slot    (slot_q),
      .heads   (heads),
      .empties (empties),
      .active  (act[k]),
      .sel     (sels[k]),
      .take    (takes[k]),
      .miss    (lmiss[k]),
      .word    (words[k])
    );
  end

  always_comb begin
    pops   = '0;
    misses = '0;
    for (int k = 0; k < NUM_LANES; k++) begin
      if (takes[k]) pops[sels[k]]   = 1'b1;
      if (lmiss[k]) misses[sels[k]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= RATE_FULL;
      slot_q    <= '0;
      lane_q    <= '0;
      valid_q   <= '0;
      ovf_flags <= '0;
      unf_flags <= '0;
    end else if (resync) begin
      mode_q  <= mode_sel;
      slot_q  <= '0;
      lane_q  <= '0;
      valid_q <= '0;
    end else begin
      slot_q    <= slot_q + 1'b1;
      lane_q    <= words;
      valid_q   <= takes;
      ovf_flags <= ovf_flags | drops;
      unf_flags <= unf_flags | misses;
    end
  end
endmodule

// File: rtl/lane_mapper_checker.sv
module lane_mapper_checker #(
  parameter int unsigned NUM_CH    = 32,
  parameter int unsigned SAMPLE_W  = 12,
  parameter int unsigned NUM_LANES = NUM_CH / 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          resync,
  input logic [NUM_LANES*SAMPLE_W-1:0] lane_data,
  input logic [NUM_LANES-1:0]          lane_valid,
  input logic [NUM_LANES-1:0]          lane_en,
  input logic [NUM_CH-1:0]             ovf_flags,
  input logic [NUM_CH-1:0]             unf_flags
);
  localparam logic [NUM_LANES-1:0] M_FULL = '1;
  localparam logic [NUM_LANES-1:0] M_HALF = M_FULL >> (NUM_LANES / 2);
  localparam logic [NUM_LANES-1:0] M_QTR  = M_FULL >> (NUM_LANES - NUM_LANES / 4);

  AST_VALID_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid & ~lane_en) == '0); // R6

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_idle
    AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_en[k] |-> lane_data[k*SAMPLE_W +: SAMPLE_W] == '0); // R6
  end

  AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    lane_en == M_FULL || lane_en == M_HALF || lane_en == M_QTR); // R2

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !resync |=> $stable(lane_en)); // R2

  AST_RESYNC_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> lane_valid == '0); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ovf_flags & $past(ovf_flags)) == $past(ovf_flags)); // R7

  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (unf_flags & $past(unf_flags)) == $past(unf_flags)); // R5
endmodule

bind lane_mapper lane_mapper_checker #(
  .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .NUM_LANES(NUM_LANES)
) u_checker (
  .clk(clk), .rst_n(rst_n), .resync(resync), .lane_data(lane_data),
  .lane_valid(lane_valid), .lane_en(lane_en), .ovf_flags(ovf_flags),
  .unf_flags(unf_flags)
);

// File: tb/lane_mapper_test.sv
module lane_mapper_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 32;
  localparam int SW  = 12;
  localparam int NL  = 16;
  localparam int DEP = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [1:0]         mode_sel = 2'd0;
  logic               resync = 1'b0;
  logic [NCH-1:0]     s_valid = '0;
  logic [NCH*SW-1:0]  s_data = '0;
  logic [NL*SW-1:0]   lane_data;
  logic [NL-1:0]      lane_valid, lane_en;
  logic [NCH-1:0]     ovf_flags, unf_flags;

  lane_mapper uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .resync(resync),
    .s_valid(s_valid), .s_data(s_data), .lane_data(lane_data),
    .lane_valid(lane_valid), .lane_en(lane_en),
    .ovf_flags(ovf_flags), .unf_flags(unf_flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string phase = "R1";

  // reference model state
  int          m_mode = 0;
  int          m_slot = 0;
  logic [SW-1:0] mq [NCH][$];
  logic [NL*SW-1:0] e_data = '0;
  logic [NL-1:0]  e_valid = '0, e_en = '1;
  logic [NCH-1:0] e_ovf = '0, e_unf = '0;

  function automatic int grp(int m);
    return (m == 0) ? 2 : (m == 1) ? 4 : 8;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_slot = 0;
      for (int c = 0; c < NCH; c++) mq[c].delete();
      e_data = '0; e_valid = '0; e_ovf = '0; e_unf = '0;
    end else if (resync) begin
      m_mode = mode_sel; m_slot = 0;
      for (int c = 0; c < NCH; c++) mq[c].delete();
      e_data = '0; e_valid = '0;
    end else begin
      int n;
      bit full_pre [NCH];
      n = grp(m_mode);
      for (int c = 0; c < NCH; c++) full_pre[c] = (mq[c].size() >= DEP);
      e_data = '0; e_valid = '0;
      for (int k = 0; k < NL; k++) begin
        if (k < NCH / n) begin
          int ch;
          ch = k * n + (m_slot % n);
          if (mq[ch].size() > 0) begin
            e_data[k*SW +: SW] = mq[ch].pop_front();
            e_valid[k] = 1'b1;
          end else e_unf[ch] = 1'b1;
        end
      end
      for (int c = 0; c < NCH; c++) begin
        if (s_valid[c]) begin
          if (full_pre[c]) e_ovf[c] = 1'b1;
          else mq[c].push_back(s_data[c*SW +: SW]);
        end
      end
      m_slot = (m_slot + 1) % 8;
    end
    begin
      int n2;
      n2 = grp(m_mode);
      for (int k = 0; k < NL; k++) e_en[k] = (k < NCH / n2);
    end
  end

  task automatic chk(string tag, logic [383:0] act, logic [383:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, phase, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      chk("R3 R4 lane_data", 384'(lane_data), 384'(e_data));
      chk("R4 R5 lane_valid", 384'(lane_valid), 384'(e_valid));
      chk("R6 lane_en", 384'(lane_en), 384'(e_en));
      chk("R7 ovf_flags", 384'(ovf_flags), 384'(e_ovf));
      chk("R5 unf_flags", 384'(unf_flags), 384'(e_unf));
    end
  end

  int seq [NCH];

  // drive one cycle: channels write when (cyc % every == c % every), or with
  // probability 1/every when rnd is set
  task automatic run(int cycles, int every, bit rnd);
    for (int t = 0; t < cycles; t++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        bit w;
        w = (every == 0) ? 1'b0 : rnd ? (($urandom % every) == 0) : ((t % every) == (c % every));
        s_valid[c] = w;
        if (w) begin
          seq[c]++;
          s_data[c*SW +: SW] = SW'((c << 7) ^ seq[c]);
        end
      end
    end
  endtask

  task automatic pulse_resync(int m);
    @(negedge clk);
    mode_sel = 2'(m);
    resync = 1'b1;
    s_valid = '1;
    @(negedge clk);
    resync = 1'b0;
    s_valid = '0;
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) seq[c] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 384'(lane_valid), 384'(0));
    chk("R1 reset mask", 384'(lane_en), 384'(16'hFFFF));
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first cycle flags", 384'(ovf_flags), 384'(0));

    phase = "R3 R4 R9 full steady";
    run(200, 2, 1'b0);
    phase = "R7 full overflow";
    run(60, 1, 1'b0);
    chk("R7 all channels dropped", 384'(ovf_flags), 384'({NCH{1'b1}}));
    phase = "R2 mode_sel without resync";
    mode_sel = 2'd2;
    run(20, 2, 1'b0);
    chk("R2 mask unchanged", 384'(lane_en), 384'(16'hFFFF));
    phase = "R8 resync to half";
    pulse_resync(1);
    chk("R8 lanes invalid after resync", 384'(lane_valid), 384'(0));
    chk("R2 half mask", 384'(lane_en), 384'(16'h00FF));
    run(200, 4, 1'b0);
    phase = "R5 idle underflow";
    run(20, 0, 1'b0);
    chk("R5 all channels starved", 384'(unf_flags), 384'({NCH{1'b1}}));
    phase = "R3 quarter random";
    pulse_resync(2);
    chk("R6 quarter mask", 384'(lane_en), 384'(16'h000F));
    run(250, 8, 1'b1);
    phase = "R2 code 3";
    pulse_resync(3);
    chk("R2 code 3 mask", 384'(lane_en), 384'(16'h000F));
    run(150, 6, 1'b1);
    phase = "R4 back to full";
    pulse_resync(0);
    run(100, 3, 1'b1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule